// File: doc/BRIEF.md
# Smart card bit-clock generator

This block derives all bit timing for an ISO 7816-style smart card port from the internal peripheral clock. No external clock input exists. Two settings fix the timing. An 8-bit divisor `N` gives a divide-by-(N+1) stage. A 2-bit prescale select `n` divides the peripheral clock by 4^n. Together they set the half period of a square card clock. One bit time is always exactly 372 card-clock periods. A bit therefore lasts 744 × 4^n × (N+1) peripheral clocks, which is the same as 1488 × 2^(2n−1) × (N+1).

Alongside the card clock the block produces two strobes, each one peripheral clock wide. One marks the end of every bit. The other marks the middle of every bit. The transmitter and the receiver time their work from these strobes. An output enable can hold the card clock low while the strobes keep running, so internal transfers continue. A run control clears every counter. The divisor and the select are sampled only at a bit boundary or while the block is stopped, so a change never produces a shortened bit.

Top module: `cardclk_gen`

## Requirements
- R1: While `run` is 0, on the next clock edge `card_clk`, `bit_end` and `bit_mid` are 0 and all counters return to zero. After reset all three outputs are 0.
- R2: After `run` rises, `bit_end` pulses every 744 × 4^n × (N+1) clocks. The first pulse is registered on the 744 × 4^n × (N+1)-th clock edge with `run` = 1.
- R3: `sel` encodings 00, 01, 10 and 11 select prescale factors 1, 4, 16 and 64. The card clock holds each level for 4^n × (N+1) clocks.
- R4: Exactly 372 card-clock periods fit in each bit. The card clock starts low after `run` rises, and it returns low on the edge that raises `bit_end`.
- R5: With `clk_out_en` = 0, `card_clk` stays 0 and `bit_end` and `bit_mid` keep their timing.
- R6: `bit_mid` pulses 372 × 4^n × (N+1) clocks after each bit start, once per bit.
- R7: A change of `div_n` or `sel` while running takes effect only from the next bit boundary. The bit in progress keeps its old length.
- R8: `bit_end` and `bit_mid` are each one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 lets the generator count; 0 clears it |
| div_n | input | 8 | Divisor value N (0..255); the stage divides by N+1 |
| sel | input | 2 | Prescale select n; the clock is divided by 4^n |
| clk_out_en | input | 1 | 1 drives the card clock out; 0 holds it low |
| card_clk | output | 1 | Square card clock, 372 periods per bit |
| bit_end | output | 1 | One-clock strobe at each bit boundary |
| bit_mid | output | 1 | One-clock strobe at the middle of each bit |

## Verification
The hardest case to reach is a settings change in the middle of a bit. The new divisor has to stay invisible until the boundary and then apply to the full next bit. The bench starts a run with a short divisor, raises `div_n` about a third of the way into the first bit, and then measures both that bit and the following one. The largest prescale is reached by choosing `N` = 0, which keeps a bit of 47,616 clocks within the run length. The behavioural model follows every clock, so the card-clock phase at each bit boundary is compared as well.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
    localparam int CC_DIV_W = 8;
    localparam int CC_SEL_W = 2;

    typedef struct packed {
        logic [CC_DIV_W-1:0] div;
        logic [CC_SEL_W-1:0] sel;
    } cc_cfg_t;

    typedef struct packed {
        cc_cfg_t cfg;
        logic    card;
    } cc_top_t;
endpackage

// File: rtl/cardclk_prescale.sv
module cardclk_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

    logic [PRE_W-1:0] lim;
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        lim   = PRE_W'((32'd1 << (2 * sel)) - 32'd1);
        tick  = !clr && (pre_q == lim);
        pre_d = pre_q + 1'b1;
        if (clr || tick) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: the prescale count never passes the selected limit
    assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= lim);
endmodule

// File: rtl/cardclk_halfdiv.sv
module cardclk_halfdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [DIV_W-1:0] lim,
    output logic             ph_next,
    output logic             period_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } hd_t;

    hd_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d       = st_q;
        wrap       = tick && (st_q.cnt == lim);
        period_end = wrap && st_q.ph;
        if (clr) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.ph  = !st_q.ph;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        ph_next = st_d.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the divide-by-(N+1) count stays within N
    assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim);
endmodule

// File: rtl/cardclk_bitcnt.sv
module cardclk_bitcnt #(
    parameter int BIT_SCK = 372,
    parameter int MID_SCK = 186
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last,
    output logic bit_end,
    output logic bit_mid
);
    localparam int CNT_W = $clog2(BIT_SCK);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fin;
        logic             mid;
    } bc_t;

    bc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        last     = step && (st_q.cnt == CNT_W'(BIT_SCK - 1));
        st_d.fin = !clr && last;
        st_d.mid = !clr && step && (st_q.cnt == CNT_W'(MID_SCK - 1));
        if (clr || last) st_d.cnt = '0;
        else if (step)   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_end = st_q.fin;
    assign bit_mid = st_q.mid;

    // R4: the card-clock period count stays below 372
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(BIT_SCK - 1));
    // R8: both strobes last a single clock
    assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !bit_end);
    assert_mid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_mid |=> !bit_mid);
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int BIT_SCK = 372,
    parameter int MID_SCK = 186
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [CC_DIV_W-1:0] div_n,
    input  logic [CC_SEL_W-1:0] sel,
    input  logic                clk_out_en,
    output logic                card_clk,
    output logic                bit_end,
    output logic                bit_mid
);
    cc_top_t st_d, st_q;
    logic    tick, ph_next, period_end, last;

    cardclk_prescale #(.SEL_W(CC_SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(!run), .sel(st_q.cfg.sel), .tick(tick)
    );

    cardclk_halfdiv #(.DIV_W(CC_DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(!run), .tick(tick),
        .lim(st_q.cfg.div), .ph_next(ph_next), .period_end(period_end)
    );

    cardclk_bitcnt #(.BIT_SCK(BIT_SCK), .MID_SCK(MID_SCK)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(period_end),
        .last(last), .bit_end(bit_end), .bit_mid(bit_mid)
    );

    always_comb begin
        st_d      = st_q;
        st_d.card = run && clk_out_en && ph_next;
        if (!run || last) begin
            st_d.cfg.div = div_n;
            st_d.cfg.sel = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign card_clk = st_q.card;

    // R1: a stopped generator drives every output low
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!card_clk && !bit_end && !bit_mid));
    // R5: a disabled output keeps the card clock low
    assert_gate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_out_en |=> !card_clk);
    // R7: settings stay frozen inside a running bit
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(st_q.cfg));
endmodule

// File: tb/cardclk_gen_test.sv
module cardclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] div_n = 8'd0;
    logic [1:0] sel = 2'd0;
    logic       clk_out_en = 1'b1;
    logic       card_clk, bit_end, bit_mid;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // behavioural reference
    int  t = 0;
    int  ref_div = 0;
    int  ref_sel = 0;
    logic e_card = 0, e_end = 0, e_mid = 0;

    always #2 clk = !clk;

    cardclk_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .div_n(div_n), .sel(sel),
        .clk_out_en(clk_out_en), .card_clk(card_clk), .bit_end(bit_end),
        .bit_mid(bit_mid)
    );

    always @(posedge clk) begin
        int half;
        cyc++;
        if (!rst_n || !run) begin
            t = 0; ref_div = div_n; ref_sel = sel;
            e_card = 0; e_end = 0; e_mid = 0;
        end else begin
            half = (1 << (2 * ref_sel)) * (ref_div + 1);
            t++;
            e_mid  = (t == 372 * half);
            e_end  = (t == 744 * half);
            e_card = (((t / half) % 2) == 1) && clk_out_en;
            if (e_end) begin
                t = 0; ref_div = div_n; ref_sel = sel;
            end
        end
    end

    // per-clock comparison against the model (R2..R6, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (card_clk !== e_card || bit_end !== e_end || bit_mid !== e_mid) begin
                fails++;
                $display("FAIL R2/R4/R6 model cyc=%0d actual card=%b end=%b mid=%b expected card=%b end=%b mid=%b",
                         cyc, card_clk, bit_end, bit_mid, e_card, e_end, e_mid);
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 195000) begin
            fails++;
            $display("FAIL watchdog actual cyc=%0d expected finish", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for the next bit_end and returns its negedge-sampled cycle
    task automatic wait_end(output int at);
        @(negedge clk);
        while (!bit_end) @(negedge clk);
        at = cyc;
    endtask

    task automatic restart(input int dv, input int sl);
        @(negedge clk);
        run = 0; div_n = 8'(dv); sel = 2'(sl);
        repeat (2) @(negedge clk);
        check("R1 idle card_clk", card_clk, 0);
        check("R1 idle bit_end", bit_end, 0);
        run = 1;
    endtask

    task automatic measure(input string req, input int dv, input int sl, input int bits);
        int start, at, prev, exp;
        exp = 744 * (1 << (2 * sl)) * (dv + 1);
        restart(dv, sl);
        start = cyc;
        prev = start;
        for (int b = 0; b < bits; b++) begin
            wait_end(at);
            check(req, at - prev, exp);
            prev = at;
        end
    endtask

    initial begin
        int start, at, prev, mid_at, highs;
        repeat (3) @(negedge clk);
        check("R1 reset card_clk", card_clk, 0);
        check("R1 reset bit_end", bit_end, 0);
        check("R1 reset bit_mid", bit_mid, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2/R3: bit length for several settings
        measure("R2 N=0 n=0 bit period", 0, 0, 3);
        measure("R3 N=2 n=1 bit period", 2, 1, 2);
        measure("R3 N=0 n=2 bit period", 0, 2, 1);
        measure("R3 N=0 n=3 bit period", 0, 3, 1);

        // R6: mid strobe position, N=3 n=0 -> half = 4
        restart(3, 0);
        start = cyc;
        @(negedge clk);
        while (!bit_mid) @(negedge clk);
        mid_at = cyc;
        check("R6 mid strobe offset", mid_at - start, 372 * 4);

        // R4: count card clock rising edges in one bit, N=0 n=0
        restart(0, 0);
        highs = 0;
        begin
            logic prev_c = 0;
            @(negedge clk);
            while (!bit_end) begin
                if (card_clk && !prev_c) highs++;
                prev_c = card_clk;
                @(negedge clk);
            end
            check("R4 card clock low at boundary", card_clk, 0);
        end
        check("R4 card periods per bit", highs, 372);

        // R5: output disabled, strobes still on time
        clk_out_en = 0;
        restart(1, 0);
        start = cyc;
        highs = 0;
        @(negedge clk);
        while (!bit_end) begin
            if (card_clk) highs++;
            @(negedge clk);
        end
        check("R5 card_clk held low", highs, 0);
        check("R5 strobe timing kept", cyc - start, 744 * 2);
        clk_out_en = 1;

        // R7: divisor change mid-bit, N=1 -> N=3
        restart(1, 0);
        start = cyc;
        repeat (500) @(negedge clk);
        div_n = 8'd3;
        wait_end(at);
        check("R7 old bit length kept", at - start, 744 * 2);
        prev = at;
        wait_end(at);
        check("R7 new bit length applied", at - prev, 744 * 4);

        // R1: dropping run clears all
        repeat (100) @(negedge clk);
        run = 0;
        @(negedge clk);
        check("R1 stop card_clk", card_clk, 0);
        check("R1 stop bit_mid", bit_mid, 0);
        measure("R1 restart from zero", 0, 0, 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule